// File: doc/BRIEF.md
# Miss Completion Tracker

This block sits on the requesting side of a directory-coherent node, between one processor and the network interface. Each coherence miss the processor issues takes a tracker entry. The entry records the kind of request and the line address. It then gathers the network replies that belong to that request and reports one completion back to the processor. A write is finished only when the home's exclusive reply has arrived and every invalidation acknowledgement has arrived. The network does not keep point-to-point order, so these may come in any order. Early acknowledgements drive a signed pending count below zero, and the count returns to zero once the exclusive reply adds the expected number.

The tracker also classifies each incoming probe (intervention or invalidation) against the lines it holds. A probe that hits an outstanding writeback is dropped. A probe that hits an unfinished write is deferred, and the tracker signals its release in the same cycle the write completes. An invalidation that hits an outstanding read marks that read, so the late data is reported as unusable. A NACK from the network produces a retry indication with the kind to reissue. An upgrade is always reissued as an exclusive read.

Top module: `miss_tracker`

## Requirements
- R1: After reset, no entry is busy, `req_ready` is 1, `req_tag` is 0, and `cpl_valid`, `retry_valid` and `rel_valid` are 0.
- R2: A request with `req_valid`=1 and `req_ready`=1 takes the lowest-numbered free entry, and `req_tag` shows that entry in the same cycle. Request kinds are 0 read, 1 exclusive read, 2 upgrade, 3 writeback. `req_ready` is 0 while all `ENTRIES` entries are busy.
- R3: A data reply (`rsp_kind`=0) to an outstanding read raises `cpl_valid` one cycle later, with `cpl_tag` equal to the entry and `cpl_usable`=1.
- R4: If an invalidation probe (`ivn_inval`=1) hits the line of an outstanding read, that read's later completion has `cpl_usable`=0.
- R5: A write (kind 1 or 2) completes one cycle after the response that makes both of these true: the exclusive reply (`rsp_kind`=1, count in `rsp_count`) has arrived, and the number of acknowledgements (`rsp_kind`=2) equals that count. Acknowledgements may come before or after the reply.
- R6: An exclusive reply with count 0 completes the write one cycle later.
- R7: A NACK (`rsp_kind`=3) to a busy entry raises `retry_valid` one cycle later with `retry_tag` equal to the entry. `retry_kind` is 1 for an upgrade and is otherwise the original kind. The entry stays busy, and any reply or acknowledgement progress it had is discarded.
- R8: A probe that hits an unfinished write, and no writeback, gets `probe_act`=1 (defer) in the same cycle. When that write completes, `rel_valid`=1 and `rel_line` is the line, in the same cycle as `cpl_valid`.
- R9: A probe that hits an outstanding writeback gets `probe_act`=2 (drop). The writeback completes one cycle after a writeback acknowledgement (`rsp_kind`=4).
- R10: A probe that hits no write or writeback entry gets `probe_act`=0 (pass).
- R11: Entries free on completion in any order. A freed entry is offered again from the next cycle.
- R12: A response to a free entry, or one whose kind does not fit the entry (for example an acknowledgement to a read), produces no completion and no retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor presents a miss |
| req_kind | input | 2 | 0 read, 1 exclusive read, 2 upgrade, 3 writeback |
| req_line | input | LINE_W | Line address of the miss |
| req_ready | output | 1 | A free entry exists |
| req_tag | output | TAG_W | Entry the miss is placed in |
| rsp_valid | input | 1 | Network response present |
| rsp_kind | input | 3 | 0 data, 1 exclusive reply, 2 ack, 3 NACK, 4 writeback ack |
| rsp_tag | input | TAG_W | Entry the response belongs to |
| rsp_count | input | CNT_W-1 | Acknowledgements to expect (exclusive reply) |
| ivn_valid | input | 1 | Incoming probe present |
| ivn_inval | input | 1 | 1 invalidation, 0 intervention |
| ivn_line | input | LINE_W | Line address of the probe |
| probe_act | output | 2 | 0 pass, 1 defer, 2 drop |
| cpl_valid | output | 1 | One completion to the processor |
| cpl_tag | output | TAG_W | Entry that completed |
| cpl_usable | output | 1 | Returned data may be installed |
| retry_valid | output | 1 | Request must be reissued |
| retry_tag | output | TAG_W | Entry to reissue |
| retry_kind | output | 2 | Kind to reissue |
| rel_valid | output | 1 | Deferred probe may now be serviced |
| rel_line | output | LINE_W | Line of the released probe |

## Verification
A corrupted pending count or reply flag appears at the ports as a write completion that comes too early or never comes. This is visible in the cycle after the acknowledgement that should, or should not, have finished the write. A lost defer or poison flag appears as a missing `rel_valid` or a wrong `cpl_usable` at the affected entry's completion. A mis-kept busy bit first shows up on `req_ready` or `req_tag` in the same cycle, or as a completion for an entry that was never allocated. The reference model runs next to the design and compares every output on every clock, so any of these is reported in the cycle it occurs.

// File: rtl/mtrk_pkg.sv
package mtrk_pkg;

  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_RDEX  = 2'd1,
    RQ_UPGR  = 2'd2,
    RQ_WBACK = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    RS_DATA   = 3'd0,
    RS_EXCL   = 3'd1,
    RS_ACK    = 3'd2,
    RS_NACK   = 3'd3,
    RS_WBDONE = 3'd4
  } rsp_kind_e;

  typedef enum logic [1:0] {
    PA_PASS  = 2'd0,
    PA_DEFER = 2'd1,
    PA_DROP  = 2'd2
  } probe_act_e;

  // Kinds that wait on invalidation acknowledgements
  function automatic logic kind_is_write(input logic [1:0] k);
    return (k == RQ_RDEX) || (k == RQ_UPGR);
  endfunction

  // Kind to send again after a NACK
  function automatic logic [1:0] reissue_kind(input logic [1:0] k);
    return (k == RQ_UPGR) ? RQ_RDEX : k;
  endfunction

endpackage

// File: rtl/mtrk_alloc.sv
module mtrk_alloc #(
  parameter int ENTRIES = 4,
  localparam int TAG_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] busy_i,
  output logic               free_any_o,
  output logic [TAG_W-1:0]   free_idx_o
);

  always_comb begin
    free_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!busy_i[i]) free_idx_o = TAG_W'(i);
    end
  end

  assign free_any_o = ~&busy_i;

endmodule

// File: rtl/mtrk_probe.sv
module mtrk_probe
  import mtrk_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 16
) (
  input  logic                            ivn_valid_i,
  input  logic                            ivn_inval_i,
  input  logic [LINE_W-1:0]               ivn_line_i,
  input  logic [ENTRIES-1:0]              busy_i,
  input  logic [ENTRIES-1:0][1:0]         kind_i,
  input  logic [ENTRIES-1:0][LINE_W-1:0]  line_i,
  output logic [1:0]                      act_o,
  output logic [ENTRIES-1:0]              poison_o,
  output logic [ENTRIES-1:0]              defer_o
);

  logic [ENTRIES-1:0] hit, wb_hit, wr_hit, rd_hit;
  logic any_wb, any_wr;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    assign hit[i]    = ivn_valid_i && busy_i[i] && (line_i[i] == ivn_line_i);
    assign wb_hit[i] = hit[i] && (kind_i[i] == RQ_WBACK);
    assign wr_hit[i] = hit[i] && kind_is_write(kind_i[i]);
    assign rd_hit[i] = hit[i] && (kind_i[i] == RQ_READ);
  end

  assign any_wb = |wb_hit;
  assign any_wr = |wr_hit;

  // Writeback outranks write; anything else passes to the cache
  always_comb begin
    if (any_wb)      act_o = PA_DROP;
    else if (any_wr) act_o = PA_DEFER;
    else             act_o = PA_PASS;
  end

  assign poison_o = rd_hit & {ENTRIES{ivn_inval_i}};
  assign defer_o  = wr_hit & {ENTRIES{~any_wb}};

endmodule

// File: rtl/mtrk_entry.sv
module mtrk_entry
  import mtrk_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [1:0]        alloc_kind_i,
  input  logic [LINE_W-1:0] alloc_line_i,
  input  logic              rsp_hit_i,
  input  logic [2:0]        rsp_kind_i,
  input  logic [CNT_W-2:0]  rsp_count_i,
  input  logic              poison_i,
  input  logic              defer_i,
  output logic              busy_o,
  output logic [1:0]        kind_o,
  output logic [LINE_W-1:0] line_o,
  output logic              fin_o,
  output logic              fin_usable_o,
  output logic              fin_defer_o,
  output logic              nack_o
);

  logic              busy_q, got_q, poi_q, def_q;
  logic [1:0]        kind_q;
  logic [LINE_W-1:0] line_q;
  logic signed [CNT_W-1:0] pend_q, pend_nx;
  logic got_nx, is_wr, reply_now, ack_now, read_done, wb_done, wr_done;

  // Pending = expected acknowledgements minus received ones
  function automatic logic signed [CNT_W-1:0] ack_step(
    input logic signed [CNT_W-1:0] cur,
    input logic [CNT_W-2:0]        add,
    input logic                    sub
  );
    return cur + $signed({1'b0, add}) - (sub ? CNT_W'(1) : CNT_W'(0));
  endfunction

  assign is_wr     = kind_is_write(kind_q);
  assign reply_now = busy_q && rsp_hit_i && is_wr &&
                     (rsp_kind_i == RS_EXCL || rsp_kind_i == RS_DATA);
  assign ack_now   = busy_q && rsp_hit_i && is_wr && (rsp_kind_i == RS_ACK);
  assign read_done = busy_q && rsp_hit_i && (kind_q == RQ_READ) && (rsp_kind_i == RS_DATA);
  assign wb_done   = busy_q && rsp_hit_i && (kind_q == RQ_WBACK) && (rsp_kind_i == RS_WBDONE);
  assign nack_o    = busy_q && rsp_hit_i && (rsp_kind_i == RS_NACK);

  assign pend_nx = ack_step(pend_q, reply_now ? rsp_count_i : '0, ack_now);
  assign got_nx  = got_q | reply_now;
  assign wr_done = (reply_now || ack_now) && got_nx && (pend_nx == '0);

  assign fin_o        = read_done | wb_done | wr_done;
  assign fin_usable_o = (kind_q == RQ_READ) ? !(poi_q | poison_i) : 1'b1;
  assign fin_defer_o  = def_q | defer_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= RQ_READ;
      line_q <= '0;
      got_q  <= 1'b0;
      pend_q <= '0;
      poi_q  <= 1'b0;
      def_q  <= 1'b0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      kind_q <= alloc_kind_i;
      line_q <= alloc_line_i;
      got_q  <= 1'b0;
      pend_q <= '0;
      poi_q  <= 1'b0;
      def_q  <= 1'b0;
    end else if (fin_o) begin
      busy_q <= 1'b0;
      got_q  <= 1'b0;
      pend_q <= '0;
      poi_q  <= 1'b0;
      def_q  <= 1'b0;
    end else begin
      poi_q <= poi_q | poison_i;
      def_q <= def_q | defer_i;
      if (nack_o) begin
        kind_q <= reissue_kind(kind_q);
        got_q  <= 1'b0;
        pend_q <= '0;
      end else begin
        got_q  <= got_nx;
        pend_q <= pend_nx;
      end
    end
  end

  assign busy_o = busy_q;
  assign kind_o = kind_q;
  assign line_o = line_q;

endmodule

// File: rtl/miss_tracker.sv
module miss_tracker
  import mtrk_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 16,
  parameter int CNT_W   = 6,
  localparam int TAG_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [LINE_W-1:0] req_line,
  output logic              req_ready,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              rsp_valid,
  input  logic [2:0]        rsp_kind,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic [CNT_W-2:0]  rsp_count,
  input  logic              ivn_valid,
  input  logic              ivn_inval,
  input  logic [LINE_W-1:0] ivn_line,
  output logic [1:0]        probe_act,
  output logic              cpl_valid,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic              cpl_usable,
  output logic              retry_valid,
  output logic [TAG_W-1:0]  retry_tag,
  output logic [1:0]        retry_kind,
  output logic              rel_valid,
  output logic [LINE_W-1:0] rel_line
);

  logic [ENTRIES-1:0]             busy, fin, fin_usable, fin_defer, nack;
  logic [ENTRIES-1:0]             alloc_vec, rsp_hit, poison, defer;
  logic [ENTRIES-1:0][1:0]        kind_v;
  logic [ENTRIES-1:0][LINE_W-1:0] line_v;
  logic                           free_any, take;
  logic [TAG_W-1:0]               free_idx;

  // Named events for the checker and for waveform reading
  logic              ev_finish, ev_nack, ev_usable, ev_release;
  logic [LINE_W-1:0] ev_line;
  logic [1:0]        ev_rekind;

  mtrk_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .busy_i    (busy),
    .free_any_o(free_any),
    .free_idx_o(free_idx)
  );

  mtrk_probe #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_probe (
    .ivn_valid_i(ivn_valid),
    .ivn_inval_i(ivn_inval),
    .ivn_line_i (ivn_line),
    .busy_i     (busy),
    .kind_i     (kind_v),
    .line_i     (line_v),
    .act_o      (probe_act),
    .poison_o   (poison),
    .defer_o    (defer)
  );

  assign take = req_valid && free_any;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign alloc_vec[i] = take && (free_idx == TAG_W'(i));
    assign rsp_hit[i]   = rsp_valid && (rsp_tag == TAG_W'(i));

    mtrk_entry #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_ent (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (alloc_vec[i]),
      .alloc_kind_i(req_kind),
      .alloc_line_i(req_line),
      .rsp_hit_i   (rsp_hit[i]),
      .rsp_kind_i  (rsp_kind),
      .rsp_count_i (rsp_count),
      .poison_i    (poison[i]),
      .defer_i     (defer[i]),
      .busy_o      (busy[i]),
      .kind_o      (kind_v[i]),
      .line_o      (line_v[i]),
      .fin_o       (fin[i]),
      .fin_usable_o(fin_usable[i]),
      .fin_defer_o (fin_defer[i]),
      .nack_o      (nack[i])
    );
  end

  // Only the addressed entry can finish or be refused in a cycle
  assign ev_finish  = |fin;
  assign ev_nack    = |nack;
  assign ev_usable  = fin_usable[rsp_tag];
  assign ev_release = fin[rsp_tag] && fin_defer[rsp_tag];
  assign ev_line    = line_v[rsp_tag];
  assign ev_rekind  = reissue_kind(kind_v[rsp_tag]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpl_valid   <= 1'b0;
      cpl_tag     <= '0;
      cpl_usable  <= 1'b0;
      retry_valid <= 1'b0;
      retry_tag   <= '0;
      retry_kind  <= RQ_READ;
      rel_valid   <= 1'b0;
      rel_line    <= '0;
    end else begin
      cpl_valid   <= ev_finish;
      retry_valid <= ev_nack;
      rel_valid   <= ev_release;
      if (ev_finish) begin
        cpl_tag    <= rsp_tag;
        cpl_usable <= ev_usable;
      end
      if (ev_nack) begin
        retry_tag  <= rsp_tag;
        retry_kind <= ev_rekind;
      end
      if (ev_release) rel_line <= ev_line;
    end
  end

  assign req_ready = free_any;
  assign req_tag   = free_idx;

endmodule

// File: rtl/mtrk_checker.sv
module mtrk_checker #(
  parameter int ENTRIES = 4,
  localparam int TAG_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ENTRIES-1:0] busy,
  input logic               req_ready,
  input logic               ivn_valid,
  input logic [1:0]         probe_act,
  input logic               cpl_valid,
  input logic [TAG_W-1:0]   cpl_tag,
  input logic               retry_valid,
  input logic [TAG_W-1:0]   retry_tag,
  input logic [1:0]         retry_kind,
  input logic               rel_valid
);

  a_r2_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy) |-> !req_ready);

  a_r3_cpl_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> ((($past(busy)) >> cpl_tag) & ENTRIES'(1)) != '0);

  a_r11_cpl_frees: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> !busy[cpl_tag]);

  a_r7_retry_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    retry_valid |-> (busy[retry_tag] && retry_kind != 2'd2));

  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpl_valid && retry_valid));

  a_r8_rel_with_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> cpl_valid);

  a_r10_act_needs_probe: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_act != 2'd0) |-> ivn_valid);

endmodule

bind miss_tracker mtrk_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .req_ready  (req_ready),
  .ivn_valid  (ivn_valid),
  .probe_act  (probe_act),
  .cpl_valid  (cpl_valid),
  .cpl_tag    (cpl_tag),
  .retry_valid(retry_valid),
  .retry_tag  (retry_tag),
  .retry_kind (retry_kind),
  .rel_valid  (rel_valid)
);

// File: tb/miss_tracker_tb.sv
module miss_tracker_tb;
  localparam int CLK_P = 10;
  localparam int N     = 4;
  localparam int LW    = 16;
  localparam int CW    = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, rsp_valid = 0, ivn_valid = 0, ivn_inval = 0;
  logic [1:0] req_kind = 0;
  logic [LW-1:0] req_line = 0, ivn_line = 0;
  logic [2:0] rsp_kind = 0;
  logic [1:0] rsp_tag = 0;
  logic [CW-2:0] rsp_count = 0;
  logic req_ready, cpl_valid, cpl_usable, retry_valid, rel_valid;
  logic [1:0] req_tag, cpl_tag, retry_tag, retry_kind, probe_act;
  logic [LW-1:0] rel_line;

  int total = 0, bad = 0;

  // Reference state
  bit m_busy[N], m_got[N], m_poi[N], m_def[N];
  int m_kind[N], m_line[N], m_pend[N];
  bit e_cpl, e_use, e_ret, e_rel;
  int e_ctag, e_rtag, e_rkind, e_rline;

  always #(CLK_P/2) clk = ~clk;

  miss_tracker #(.ENTRIES(N), .LINE_W(LW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_line(req_line),
    .req_ready(req_ready), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_tag(rsp_tag), .rsp_count(rsp_count),
    .ivn_valid(ivn_valid), .ivn_inval(ivn_inval), .ivn_line(ivn_line),
    .probe_act(probe_act),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_usable(cpl_usable),
    .retry_valid(retry_valid), .retry_tag(retry_tag), .retry_kind(retry_kind),
    .rel_valid(rel_valid), .rel_line(rel_line)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic check_regs(input string rq);
    chk(cpl_valid == e_cpl, rq, "cpl_valid", cpl_valid, e_cpl);
    if (e_cpl) begin
      chk(cpl_tag == e_ctag, rq, "cpl_tag", cpl_tag, e_ctag);
      chk(cpl_usable == e_use, rq, "cpl_usable", cpl_usable, e_use);
    end
    chk(retry_valid == e_ret, rq, "retry_valid", retry_valid, e_ret);
    if (e_ret) begin
      chk(retry_tag == e_rtag, rq, "retry_tag", retry_tag, e_rtag);
      chk(retry_kind == e_rkind, rq, "retry_kind", retry_kind, e_rkind);
    end
    chk(rel_valid == e_rel, rq, "rel_valid", rel_valid, e_rel);
    if (e_rel) chk(rel_line == e_rline, rq, "rel_line", rel_line, e_rline);
  endtask

  // One clock: drive, compare same-cycle outputs, step model, compare registered outputs
  task automatic step(input bit rv, input int rk, input int rl,
                      input bit sv, input int sk, input int st, input int sc,
                      input bit pv, input bit pk, input int pl, input string rq);
    int fidx;
    bit any_wb, any_wr, fin;
    int k;
    req_valid = rv; req_kind = 2'(rk); req_line = LW'(rl);
    rsp_valid = sv; rsp_kind = 3'(sk); rsp_tag = 2'(st); rsp_count = (CW-1)'(sc);
    ivn_valid = pv; ivn_inval = pk; ivn_line = LW'(pl);
    #1;
    fidx = -1;
    for (int i = 0; i < N; i++) if (!m_busy[i] && fidx < 0) fidx = i;
    chk(req_ready == (fidx >= 0), rq, "req_ready", req_ready, fidx >= 0);
    if (fidx >= 0) chk(req_tag == fidx, rq, "req_tag", req_tag, fidx);
    any_wb = 0; any_wr = 0;
    if (pv) begin
      for (int i = 0; i < N; i++) if (m_busy[i] && m_line[i] == pl) begin
        if (m_kind[i] == 3) any_wb = 1;
        if (m_kind[i] == 1 || m_kind[i] == 2) any_wr = 1;
      end
      chk(probe_act == (any_wb ? 2 : any_wr ? 1 : 0), rq, "probe_act", probe_act,
          any_wb ? 2 : any_wr ? 1 : 0);
      for (int i = 0; i < N; i++) if (m_busy[i] && m_line[i] == pl) begin
        if (m_kind[i] == 0 && pk) m_poi[i] = 1;
        if ((m_kind[i] == 1 || m_kind[i] == 2) && !any_wb) m_def[i] = 1;
      end
    end
    e_cpl = 0; e_ret = 0; e_rel = 0;
    if (sv && m_busy[st]) begin
      k = m_kind[st];
      fin = 0;
      if (sk == 3) begin
        e_ret = 1; e_rtag = st; e_rkind = (k == 2) ? 1 : k;
        m_kind[st] = e_rkind; m_got[st] = 0; m_pend[st] = 0;
      end else if (k == 0) begin
        if (sk == 0) begin fin = 1; e_use = !m_poi[st]; end
      end else if (k == 3) begin
        if (sk == 4) begin fin = 1; e_use = 1; end
      end else if (sk == 0 || sk == 1 || sk == 2) begin
        if (sk == 2) m_pend[st] -= 1;
        else begin m_got[st] = 1; m_pend[st] += sc; end
        if (m_got[st] && m_pend[st] == 0) begin fin = 1; e_use = 1; end
      end
      if (fin) begin
        e_cpl = 1; e_ctag = st; e_rel = m_def[st]; e_rline = m_line[st];
        m_busy[st] = 0; m_got[st] = 0; m_pend[st] = 0; m_poi[st] = 0; m_def[st] = 0;
      end
    end
    if (rv && fidx >= 0) begin
      m_busy[fidx] = 1; m_kind[fidx] = rk; m_line[fidx] = rl;
      m_got[fidx] = 0; m_pend[fidx] = 0; m_poi[fidx] = 0; m_def[fidx] = 0;
    end
    @(posedge clk); #1;
    check_regs(rq);
  endtask

  task automatic req(input int k, input int l, input string rq);
    step(1, k, l, 0, 0, 0, 0, 0, 0, 0, rq);
  endtask
  task automatic rsp(input int k, input int t, input int c, input string rq);
    step(0, 0, 0, 1, k, t, c, 0, 0, 0, rq);
  endtask
  task automatic probe(input bit inv, input int l, input string rq);
    step(0, 0, 0, 0, 0, 0, 0, 1, inv, l, rq);
  endtask
  task automatic idle(input string rq);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, rq);
  endtask

  initial begin : watchdog
    #(CLK_P * 50000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_busy[i] = 0; m_got[i] = 0; m_poi[i] = 0; m_def[i] = 0;
      m_kind[i] = 0; m_line[i] = 0; m_pend[i] = 0;
    end
    e_cpl = 0; e_ret = 0; e_rel = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1 reset state
    chk(req_ready == 1, "R1", "req_ready", req_ready, 1);
    chk(req_tag == 0, "R1", "req_tag", req_tag, 0);
    check_regs("R1");
    idle("R1");

    // R3 simple read
    req(0, 'h10, "R2");
    rsp(0, 0, 0, "R3");

    // R2 fill every entry
    req(1, 'h100, "R2");
    req(2, 'h200, "R2");
    req(3, 'h300, "R2");
    req(0, 'h400, "R2");
    req(0, 'h500, "R2");           // refused while full
    // R12 stray acknowledgement to a read
    rsp(2, 3, 0, "R12");
    // R8 defer against unfinished write, R5 early acknowledgements
    probe(0, 'h100, "R8");
    rsp(2, 0, 0, "R5");
    rsp(2, 0, 0, "R5");
    rsp(1, 0, 2, "R5");
    // R11 reuse the freed slot
    req(1, 'h600, "R11");
    // R7 upgrade refused, reissued as exclusive read
    rsp(3, 1, 0, "R7");
    rsp(1, 1, 1, "R5");
    rsp(2, 1, 0, "R5");
    // R9 drop against writeback
    probe(0, 'h300, "R9");
    probe(1, 'h300, "R9");
    rsp(4, 2, 0, "R9");
    // R4 invalidation poisons outstanding read
    probe(1, 'h400, "R4");
    rsp(0, 3, 0, "R4");
    // R10 unrelated and read-only probes pass
    probe(0, 'h777, "R10");
    // R6 zero-count reply
    rsp(1, 0, 0, "R6");
    // R12 response to free entry
    rsp(0, 2, 0, "R12");
    // R7 read refused keeps its kind
    req(0, 'h800, "R2");
    probe(0, 'h800, "R10");
    rsp(3, 0, 0, "R7");
    rsp(0, 0, 0, "R3");
    // R11 out-of-order completion
    req(1, 'h900, "R11");
    req(3, 'hA00, "R11");
    rsp(4, 1, 0, "R11");
    req(0, 'hB00, "R11");
    rsp(1, 0, 3, "R5");
    rsp(2, 0, 0, "R5");
    rsp(2, 0, 0, "R5");
    rsp(2, 0, 0, "R5");
    rsp(0, 1, 0, "R11");
    idle("R11");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule